// File: doc/BRIEF.md
# Per-Channel Overflow Monitor with Hold Timeout

This block watches four converter channels for an over-range condition. Each channel delivers a one-cycle over-range indication. The block keeps a sticky status bit per channel, and software reads these bits and clears them with a clear pulse. It also forms a single combined active-low flag. Only the channels that the enable vector lets through can pull this flag low.

The flag is built for open-drain use, so a low level means "overflow seen". It stays low for a fixed number of sample periods after the most recent enabled over-range, and then releases. A hold counter restarts from its full value on every new enabled over-range. It counts down once per sample-rate strobe. The default hold is 2^17−1 sample periods.

Top module: `ovf_monitor`

## Requirements
- R1: During and right after a synchronous reset, `ovf_n` is 1 and every bit of `ovf_status` is 0.
- R2: An over-range on channel k (`ovr_in[k]`=1 in a cycle) sets `ovf_status[k]` at the next clock edge. Bit k of every vector is channel k, and other status bits are unchanged.
- R3: A set status bit stays set in every cycle where `status_clear` is 0.
- R4: `status_clear`=1 zeroes all status bits at the next edge. A channel whose `ovr_in` bit is 1 in that same cycle keeps its bit set.
- R5: An over-range on a channel with `ch_enable[k]`=1 drives `ovf_n` low at the next clock edge.
- R6: After the last enabled over-range, `ovf_n` stays low until HOLD_TICKS strobes of `rate_tick` have occurred. It goes high at the edge that takes the HOLD_TICKS-th strobe.
- R7: A new enabled over-range reloads the hold to its full HOLD_TICKS. This holds even when the over-range coincides with a `rate_tick`.
- R8: A channel with `ch_enable[k]`=0 still sets its status bit. It neither drives `ovf_n` low nor reloads the hold.
- R9: Clock cycles without `rate_tick` do not shorten the hold.
- R10: `status_clear` has no effect on `ovf_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_in | input | NUM_CH | Per-channel over-range indication, one bit per channel |
| rate_tick | input | 1 | One-cycle strobe per sample period |
| ch_enable | input | NUM_CH | 1 = channel may drive the combined flag |
| status_clear | input | 1 | Read-clear pulse for the status bits |
| ovf_n | output | 1 | Combined overflow flag, active low, registered |
| ovf_status | output | NUM_CH | Sticky per-channel overflow status, registered |

## Verification
The bench builds the block with four channels and HOLD_TICKS set to 6. With that value, the full hold window, its exact release edge and the reload cases can all be counted strobe by strobe. The channel count stays at its default so the masking of a single channel is exercised across the whole vector. The 2^17−1 default uses the same counter logic with a wider register.

// File: rtl/ovf_pkg.sv
`timescale 1ns/1ps
package ovf_pkg;
  // Width needed to hold values 0..lim
  function automatic int unsigned hold_width(input int unsigned lim);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= lim) w++;
    return w;
  endfunction
endpackage

// File: rtl/ovf_sticky_bank.sv
`timescale 1ns/1ps
module ovf_sticky_bank #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              clr,
  output logic [NUM_CH-1:0] sticky
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) sticky[g] <= 1'b0;
      else     sticky[g] <= (sticky[g] & ~clr) | set_vec[g];
    end
  end
endmodule

// File: rtl/ovf_hold_timer.sv
`timescale 1ns/1ps
module ovf_hold_timer
  import ovf_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 131071
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic tick,
  output logic hold_n
);
  localparam int unsigned CNT_W = hold_width(HOLD_TICKS);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)                  cnt_d = FULL;
    else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_n <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      hold_n <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/ovf_monitor.sv
`timescale 1ns/1ps
module ovf_monitor #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned HOLD_TICKS = 131071
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ovr_in,
  input  logic              rate_tick,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              status_clear,
  output logic              ovf_n,
  output logic [NUM_CH-1:0] ovf_status
);
  logic flag_hit;

  assign flag_hit = |(ovr_in & ch_enable);

  ovf_sticky_bank #(.NUM_CH(NUM_CH)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (ovr_in),
    .clr     (status_clear),
    .sticky  (ovf_status)
  );

  ovf_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .reload (flag_hit),
    .tick   (rate_tick),
    .hold_n (ovf_n)
  );
endmodule

// File: rtl/ovf_monitor_chk.sv
`timescale 1ns/1ps
module ovf_monitor_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ovr_in,
  input logic              rate_tick,
  input logic [NUM_CH-1:0] ch_enable,
  input logic              status_clear,
  input logic              ovf_n,
  input logic [NUM_CH-1:0] ovf_status
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      reset_state_chk: assert (ovf_n && ovf_status == '0);
    end
  end

  // R2
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|ovr_in) |=> ((ovf_status & $past(ovr_in)) == $past(ovr_in)));

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !status_clear |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

  // R4
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    status_clear |=> ((ovf_status & ~$past(ovr_in)) == '0));

  // R5
  flag_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ovr_in & ch_enable)) |=> !ovf_n);

  // R6
  flag_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_n) |-> ($past(rate_tick) && ($past(ovr_in & ch_enable) == '0)));
endmodule

bind ovf_monitor ovf_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ovr_in       (ovr_in),
  .rate_tick    (rate_tick),
  .ch_enable    (ch_enable),
  .status_clear (status_clear),
  .ovf_n        (ovf_n),
  .ovf_status   (ovf_status)
);

// File: tb/sim_ovf_monitor.sv
`timescale 1ns/1ps
module sim_ovf_monitor;
  localparam int unsigned NCH  = 4;
  localparam int unsigned HOLD = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ovr_in = '0;
  logic           rate_tick = 1'b0;
  logic [NCH-1:0] ch_enable = '1;
  logic           status_clear = 1'b0;
  logic           ovf_n;
  logic [NCH-1:0] ovf_status;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ovf_monitor #(.NUM_CH(NCH), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst(rst), .ovr_in(ovr_in), .rate_tick(rate_tick),
    .ch_enable(ch_enable), .status_clear(status_clear),
    .ovf_n(ovf_n), .ovf_status(ovf_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock with the given inputs, then inputs back to idle
  task automatic cyc(input logic [NCH-1:0] ovr, input logic tk, input logic clr);
    ovr_in = ovr; rate_tick = tk; status_clear = clr;
    @(negedge clk);
    ovr_in = '0; rate_tick = 1'b0; status_clear = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; ch_enable = '1;
    cyc('0, 1'b0, 1'b0);
    cyc('0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ovf_n", 32'(ovf_n), 32'd1);
    chk("R1 status", 32'(ovf_status), 32'd0);
  endtask

  task automatic t_set_sticky();
    do_reset();
    cyc(4'b0010, 1'b0, 1'b0);
    chk("R2 status ch1", 32'(ovf_status), 32'b0010);
    chk("R5 flag low", 32'(ovf_n), 32'd0);
    for (int i = 0; i < 3; i++) cyc('0, 1'b0, 1'b0);
    chk("R3 sticky", 32'(ovf_status), 32'b0010);
    cyc(4'b1000, 1'b0, 1'b0);
    chk("R2 status ch3 added", 32'(ovf_status), 32'b1010);
  endtask

  task automatic t_clear();
    do_reset();
    cyc(4'b0011, 1'b0, 1'b0);
    cyc('0, 1'b0, 1'b1);
    chk("R4 cleared", 32'(ovf_status), 32'd0);
    chk("R10 flag kept", 32'(ovf_n), 32'd0);
    cyc(4'b0100, 1'b0, 1'b1);
    chk("R4 same-cycle set", 32'(ovf_status), 32'b0100);
  endtask

  task automatic t_timeout();
    do_reset();
    cyc(4'b0001, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc('0, 1'b0, 1'b0);
    chk("R9 no tick no release", 32'(ovf_n), 32'd0);
    for (int i = 0; i < HOLD - 1; i++) cyc('0, 1'b1, 1'b0);
    chk("R6 low before last tick", 32'(ovf_n), 32'd0);
    cyc('0, 1'b1, 1'b0);
    chk("R6 released", 32'(ovf_n), 32'd1);
  endtask

  task automatic t_restart();
    do_reset();
    cyc(4'b0001, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc('0, 1'b1, 1'b0);
    cyc(4'b0100, 1'b0, 1'b0);
    for (int i = 0; i < HOLD - 1; i++) cyc('0, 1'b1, 1'b0);
    chk("R7 reload keeps low", 32'(ovf_n), 32'd0);
    cyc('0, 1'b1, 1'b0);
    chk("R7 release after reload", 32'(ovf_n), 32'd1);
    cyc(4'b0010, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc('0, 1'b1, 1'b0);
    cyc(4'b0010, 1'b1, 1'b0);
    for (int i = 0; i < HOLD - 1; i++) cyc('0, 1'b1, 1'b0);
    chk("R7 reload with tick keeps low", 32'(ovf_n), 32'd0);
    cyc('0, 1'b1, 1'b0);
    chk("R7 release after tick reload", 32'(ovf_n), 32'd1);
  endtask

  task automatic t_mask();
    do_reset();
    ch_enable = 4'b1110;
    cyc(4'b0001, 1'b0, 1'b0);
    chk("R8 masked status set", 32'(ovf_status), 32'b0001);
    chk("R8 masked no flag", 32'(ovf_n), 32'd1);
    cyc(4'b0010, 1'b0, 1'b0);
    for (int i = 0; i < HOLD - 2; i++) cyc('0, 1'b1, 1'b0);
    cyc(4'b0001, 1'b0, 1'b0);
    cyc('0, 1'b1, 1'b0);
    chk("R8 low one tick left", 32'(ovf_n), 32'd0);
    cyc('0, 1'b1, 1'b0);
    chk("R8 masked no reload", 32'(ovf_n), 32'd1);
    chk("R8 status both", 32'(ovf_status), 32'b0011);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_set_sticky();
    t_clear();
    t_timeout();
    t_restart();
    t_mask();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule